// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a stereo serial audio stream into parallel samples. The stream uses three wires: a bit clock, a frame clock and a data line. All three are oversampled in the system clock domain. The block never clocks anything from the serial clocks. It synchronises them and reacts only to the rising edges of the bit clock that it detects.

A 3-bit format code selects the framing:
- right-justified words of 16, 20 or 24 bits;
- a left-justified 24-bit word;
- I2S-style framing, in which the word starts one bit clock late and the left and right levels of the frame clock are swapped.

Both channels of a frame come out together as 24-bit signed values, with a one-cycle valid pulse. Shorter words are sign-extended. The sampling clock and any filtering stay outside the block.

A new format code is picked up only where a frame begins. The frame that starts at that point is dropped, because its framing is not trustworthy. For the same reason, the first frame after reset is never delivered.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted, `valid_o` is low and `left_o` and `right_o` are all zero.
- R2: Data is sampled on the rising edge of the bit clock, MSB first, in two's complement. At the bit-clock rising edge that opens the next frame, both channels of the previous frame appear together. They come with a single-cycle `valid_o` pulse, 3 system clocks after the bit clock rises (two synchroniser stages plus one output register).
- R3: Code 0 is 16-bit right-justified: the last 16 bits of each half frame are the word, sign-extended to 24 bits, and earlier bits are ignored.
- R4: Code 1 is 20-bit right-justified: the last 20 bits of each half are the word, sign-extended, and earlier bits are ignored.
- R5: Code 4 is 24-bit right-justified: the last 24 bits of each half are the word, and earlier bits are ignored.
- R6: Code 2 is left-justified: the first 24 bits after a frame-clock transition are the word, and later bits are ignored. 16- or 20-bit data padded with zero LSBs comes out unchanged.
- R7: Code 3 is I2S-style: frame clock low is the left channel, and the MSB arrives on the second bit clock of each half. This needs at least 25 bit clocks per half.
- R8: For codes 0, 1, 2 and 4, frame clock high is the left channel, and a frame is the left half followed by the right half.
- R9: Decoding does not depend on the number of bit clocks per half frame, from the format minimum (16, 20, 24, or 25 for code 3) up to 32 and beyond.
- R10: Codes 5, 6 and 7 decode as code 0. Switching among codes 0, 5, 6 and 7 is not a format change.
- R11: A change of the format code is adopted at the next frame start. No output is produced for the frame that begins there, and the frame that ended there is decoded with the old code.
- R12: The first complete frame after reset produces no output.
- R13: `left_o` and `right_o` hold their values in every cycle in which `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than four times the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel_i | input | 3 | Framing format code |
| bit_clk_i | input | 1 | Serial bit clock, asynchronous |
| frame_clk_i | input | 1 | Serial frame clock, selects the channel |
| ser_data_i | input | 1 | Serial data line |
| left_o | output | 24 | Left sample of the last delivered frame |
| right_o | output | 24 | Right sample of the last delivered frame |
| valid_o | output | 1 | One-cycle pulse when a new sample pair is presented |

## Verification
Every result is due exactly three system clocks after the bench raises the bit clock for the first bit of the frame that follows the finished one. The bench records the cycle number of each frame's first bit-clock rising edge, and a monitor records the cycle of every `valid_o` pulse. Each delivered pair is then checked both for its value and for that three-cycle distance, with all sampling done on falling clock edges. Dropped frames (after a format change or after reset) show up as a mismatch in the ordered list and count of pulses. Output stability between pulses is watched on every cycle.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  localparam int SAMPLE_W = 24;
  localparam int CNT_W    = 6;

  typedef enum logic [2:0] {
    FMT_RJ16 = 3'd0,
    FMT_RJ20 = 3'd1,
    FMT_LJ24 = 3'd2,
    FMT_I2S  = 3'd3,
    FMT_RJ24 = 3'd4
  } fmt_t;

  // unused codes fold onto the 16-bit right-justified format
  function automatic fmt_t fmt_norm(input logic [2:0] code);
    case (code)
      3'd1:    return FMT_RJ20;
      3'd2:    return FMT_LJ24;
      3'd3:    return FMT_I2S;
      3'd4:    return FMT_RJ24;
      default: return FMT_RJ16;
    endcase
  endfunction

  // frame clock level that marks the left channel
  function automatic logic left_level(input fmt_t f);
    return (f != FMT_I2S);
  endfunction

  // does the bit at position pos of a half frame enter the shifter
  function automatic logic take_bit(input fmt_t f, input logic [CNT_W-1:0] pos);
    case (f)
      FMT_LJ24: return (pos < CNT_W'(SAMPLE_W));
      FMT_I2S:  return (pos != '0) && (pos <= CNT_W'(SAMPLE_W));
      default:  return 1'b1;
    endcase
  endfunction

  // sign extension of the shifter contents to a full sample
  function automatic logic [SAMPLE_W-1:0] align(input fmt_t f, input logic [SAMPLE_W-1:0] sh);
    case (f)
      FMT_RJ16: return {{(SAMPLE_W-16){sh[15]}}, sh[15:0]};
      FMT_RJ20: return {{(SAMPLE_W-20){sh[19]}}, sh[19:0]};
      default:  return sh;
    endcase
  endfunction
endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/aud_rx_shift.sv
module aud_rx_shift
  import aud_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_s,
  input  logic                lr_s,
  input  logic                sd_s,
  input  fmt_t                fmt,
  output logic                half_end,
  output logic                ended_left,
  output logic [SAMPLE_W-1:0] half_word
);
  logic                bclk_q;
  logic                bit_evt;
  logic                seen;
  logic                lr_q;
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    cnt_nx;
  logic [SAMPLE_W-1:0] sh;

  assign bit_evt    = bclk_s & ~bclk_q;
  assign half_end   = bit_evt & seen & (lr_s ^ lr_q);
  assign ended_left = (lr_q == left_level(fmt));
  assign half_word  = align(fmt, sh);

  always_comb begin
    if (half_end)  cnt_nx = '0;
    else if (&cnt) cnt_nx = cnt;
    else           cnt_nx = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      seen   <= 1'b0;
      lr_q   <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
    end else begin
      bclk_q <= bclk_s;
      if (bit_evt) begin
        seen <= 1'b1;
        lr_q <= lr_s;
        cnt  <= cnt_nx;
        if (take_bit(fmt, cnt_nx)) sh <= {sh[SAMPLE_W-2:0], sd_s};
      end
    end
  end
endmodule

// File: rtl/aud_rx_frame.sv
module aud_rx_frame
  import aud_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                half_end,
  input  logic                ended_left,
  input  logic [SAMPLE_W-1:0] half_word,
  input  logic [2:0]          fmt_code,
  output fmt_t                fmt_act,
  output logic                frame_start,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  fmt_t                fmt_new;
  logic                frame_ok;
  logic [SAMPLE_W-1:0] left_hold;

  assign fmt_new     = fmt_norm(fmt_code);
  assign frame_start = half_end & ~ended_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_act   <= FMT_RJ16;
      frame_ok  <= 1'b0;
      left_hold <= '0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (half_end && ended_left) begin
        left_hold <= half_word;
      end
      if (frame_start) begin
        if (frame_ok) begin
          left_o  <= left_hold;
          right_o <= half_word;
          valid_o <= 1'b1;
        end
        frame_ok <= (fmt_new == fmt_act);
        fmt_act  <= fmt_new;
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import aud_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          fmt_sel_i,
  input  logic                bit_clk_i,
  input  logic                frame_clk_i,
  input  logic                ser_data_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  logic [2:0]          sync_q;
  logic                half_end;
  logic                ended_left;
  logic [SAMPLE_W-1:0] half_word;
  logic                frame_start;
  fmt_t                fmt_act;

  aud_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({bit_clk_i, frame_clk_i, ser_data_i}),
    .q     (sync_q)
  );

  aud_rx_shift u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk_s     (sync_q[2]),
    .lr_s       (sync_q[1]),
    .sd_s       (sync_q[0]),
    .fmt        (fmt_act),
    .half_end   (half_end),
    .ended_left (ended_left),
    .half_word  (half_word)
  );

  aud_rx_frame u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .half_end    (half_end),
    .ended_left  (ended_left),
    .half_word   (half_word),
    .fmt_code    (fmt_sel_i),
    .fmt_act     (fmt_act),
    .frame_start (frame_start),
    .left_o      (left_o),
    .right_o     (right_o),
    .valid_o     (valid_o)
  );
endmodule

// File: rtl/aud_rx_chk.sv
module aud_rx_chk
  import aud_rx_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                valid_o,
  input logic                frame_start,
  input logic [SAMPLE_W-1:0] left_o,
  input logic [SAMPLE_W-1:0] right_o,
  input logic [2:0]          fmt_act
);
  AST_VALID_AT_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(frame_start)); // R2
  AST_VALID_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o))); // R13
  AST_FMT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_start) |-> $stable(fmt_act)); // R11
  AST_FMT_FOLDED: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_act <= 3'd4); // R10
endmodule

bind serial_audio_rx aud_rx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .valid_o     (valid_o),
  .frame_start (frame_start),
  .left_o      (left_o),
  .right_o     (right_o),
  .fmt_act     (fmt_act)
);

// File: tb/sim_serial_audio_rx.sv
module sim_serial_audio_rx;
  localparam int LAT   = 3;
  localparam int NV    = 18;
  localparam int I2S_AT = 15;

  // {code[2:0], bits per half[6:0], left[23:0], right[23:0]}
  localparam logic [57:0] VEC [NV] = '{
    {3'd0, 7'd16, 24'h007FFF, 24'h008000},
    {3'd0, 7'd16, 24'h001234, 24'h00F00F},
    {3'd0, 7'd32, 24'h00ABCD, 24'h007001},
    {3'd1, 7'd20, 24'h080001, 24'h07FFFF},
    {3'd1, 7'd20, 24'h080001, 24'h07FFFF},
    {3'd1, 7'd32, 24'h0ABCDE, 24'h012345},
    {3'd4, 7'd24, 24'h800000, 24'h7FFFFF},
    {3'd4, 7'd24, 24'h800000, 24'h7FFFFF},
    {3'd4, 7'd32, 24'h123456, 24'hFEDCBA},
    {3'd2, 7'd24, 24'hA55A01, 24'h5AA5FE},
    {3'd2, 7'd24, 24'hA55A01, 24'h5AA5FE},
    {3'd2, 7'd32, 24'h123400, 24'h89ABC0},
    {3'd5, 7'd32, 24'h00BEEF, 24'h004321},
    {3'd7, 7'd16, 24'h004321, 24'h00C0DE},
    {3'd6, 7'd32, 24'h00FFFF, 24'h000001},
    {3'd3, 7'd25, 24'hC00003, 24'h3FFFFC},
    {3'd3, 7'd25, 24'hC00003, 24'h3FFFFC},
    {3'd3, 7'd32, 24'h654321, 24'h9ABCDE}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  fmt = 3'd0;
  logic        bclk = 1'b0;
  logic        lr = 1'b0;
  logic        sd = 1'b0;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int got_n = 0, exp_n = 0, fidx = 0, stab_viol = 0;
  logic [23:0] got_l [64], got_r [64], exp_l [64], exp_r [64];
  int          got_c [64], exp_f [64], fstart [128];
  string       exp_req [64];
  logic [23:0] prev_l = '0, prev_r = '0;
  logic [2:0]  cur_norm = 3'd0;
  logic        primed = 1'b0;
  logic        done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_audio_rx u0 (
    .clk (clk), .rst_n (rst_n), .fmt_sel_i (fmt),
    .bit_clk_i (bclk), .frame_clk_i (lr), .ser_data_i (sd),
    .left_o (left_o), .right_o (right_o), .valid_o (valid_o)
  );

  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (got_n < 64) begin
        got_l[got_n] <= left_o;
        got_r[got_n] <= right_o;
        got_c[got_n] <= cyc;
      end
      got_n <= got_n + 1;
    end else if (rst_n && (left_o !== prev_l || right_o !== prev_r)) begin
      stab_viol <= stab_viol + 1;
    end
    prev_l <= left_o;
    prev_r <= right_o;
  end

  task automatic check(input logic ok, input string req, input logic [47:0] act, input logic [47:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [2:0] norm3(input logic [2:0] c);
    return (c > 3'd4) ? 3'd0 : c;
  endfunction

  function automatic logic [23:0] exp_word(input logic [2:0] c, input logic [23:0] w);
    case (norm3(c))
      3'd0:    return {{8{w[15]}}, w[15:0]};
      3'd1:    return {{4{w[19]}}, w[19:0]};
      default: return w;
    endcase
  endfunction

  function automatic logic wire_bit(input logic [2:0] c, input int h, input int j, input logic [23:0] w);
    int n;
    logic junk;
    junk = (j % 3 == 1);
    case (norm3(c))
      3'd2: return (j < 24) ? w[23-j] : junk;
      3'd3: return (j >= 1 && j <= 24) ? w[24-j] : junk;
      3'd1: n = 20;
      3'd4: n = 24;
      default: n = 16;
    endcase
    return (j >= h - n) ? w[n-1-(j-(h-n))] : junk;
  endfunction

  function automatic string req_of(input logic [2:0] c, input int h);
    string s;
    case (c)
      3'd0: s = "R3,R8";
      3'd1: s = "R4,R8";
      3'd2: s = "R6,R8";
      3'd3: s = "R7";
      3'd4: s = "R5,R8";
      default: s = "R10";
    endcase
    if (h == 32) s = {s, ",R9"};
    return s;
  endfunction

  task automatic send_bit(input logic l, input logic d, input logic mark);
    @(negedge clk);
    bclk = 1'b0; lr = l; sd = d;
    @(negedge clk);
    @(negedge clk);
    bclk = 1'b1;
    if (mark) fstart[fidx] = cyc;
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [2:0] c, input int h, input logic [23:0] lw, input logic [23:0] rw);
    logic ll;
    ll = (norm3(c) != 3'd3);
    for (int j = 0; j < h; j++) send_bit(ll, wire_bit(c, h, j, lw), j == 0);
    for (int j = 0; j < h; j++) send_bit(~ll, wire_bit(c, h, j, rw), 1'b0);
    fidx++;
  endtask

  task automatic play(input logic [2:0] c, input int h, input logic [23:0] lw, input logic [23:0] rw);
    logic emit;
    emit = primed && (norm3(c) == cur_norm);
    cur_norm = norm3(c);
    fmt = c;
    if (emit && exp_n < 64) begin
      exp_l[exp_n] = exp_word(c, lw);
      exp_r[exp_n] = exp_word(c, rw);
      exp_f[exp_n] = fidx;
      exp_req[exp_n] = req_of(c, h);
      exp_n++;
    end
    send_frame(c, h, lw, rw);
    primed = 1'b1;
  endtask

  task automatic do_reset(input logic [2:0] c);
    @(negedge clk);
    rst_n = 1'b0; bclk = 1'b0; lr = 1'b0; sd = 1'b0; fmt = c;
    repeat (5) @(negedge clk);
    // R1: reset state at the ports
    check(!valid_o && left_o == '0 && right_o == '0, "R1",
          {left_o, right_o}, 48'h0);
    rst_n = 1'b1;
    cur_norm = norm3(c);
    primed = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    do_reset(3'd0);
    for (int i = 0; i < NV; i++) begin
      if (i == I2S_AT) begin
        send_frame(fmt, 16, 24'h0, 24'h0); // flush: opens the frame that delivers the last one
        repeat (8) @(negedge clk);
        do_reset(3'd3);
      end
      play(VEC[i][57:55], int'(VEC[i][54:48]), VEC[i][47:24], VEC[i][23:0]);
    end
    send_frame(fmt, 25, 24'h0, 24'h0);
    repeat (8) @(negedge clk);

    // R11, R12: dropped frames show as the pulse count
    check(got_n == exp_n, "R11,R12 count", 48'(got_n), 48'(exp_n));
    for (int k = 0; k < exp_n && k < 64; k++) begin
      check(got_l[k] == exp_l[k] && got_r[k] == exp_r[k], exp_req[k],
            {got_l[k], got_r[k]}, {exp_l[k], exp_r[k]});
      // R2: pair due LAT clocks after the next frame's first bit-clock rise
      check(got_c[k] == fstart[exp_f[k] + 1] + LAT, "R2 latency",
            48'(got_c[k]), 48'(fstart[exp_f[k] + 1] + LAT));
    end
    // R13: outputs steady between pulses
    check(stab_viol == 0, "R13", 48'(stab_viol), 48'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule